// File: doc/BRIEF.md
# Status Flag Unit with Condition Evaluator

This block sits beside a 32-bit integer datapath. It forms the result of an add, subtract, shifted move or bitwise AND. On request it records the negative, zero, carry and overflow status of that result in a registered four-bit flag set. Two of the operations are test forms of add and subtract. They update the flags like their plain forms, but they also raise a signal that tells the register file to drop the result.

A second, purely combinational path takes a four-bit condition field and decides from the registered flags whether a conditional instruction should execute. Because the decision reads the stored flags, an instruction issued in the cycle after a flag-setting operation sees that operation's status. The shifter, register file and instruction decoder sit outside the block. The shifter supplies its carry-out as a single input.

Top module: `flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all four flags (N, Z, C, V) to 0 at the next clock edge.
- R2: The flags load on a rising edge only when `op_valid` and `set_flags` are both high. In every other cycle they keep their value.
- R3: On a load, N takes bit 31 of `result`, and Z is 1 exactly when all 32 bits of `result` are 0.
- R4: For op code 0 (add) and op code 1 (add-test), `result` = a + b modulo 2^32. C is the carry out of bit 31, and V is 1 when a and b share a sign bit and the result's sign differs from it.
- R5: For op code 2 (subtract) and op code 3 (subtract-test), `result` = a − b modulo 2^32. C is 1 when no borrow occurs (a ≥ b unsigned) and 0 otherwise, so 5 − 6 gives C = 0. V is 1 when the sign bits of a and b differ and the result's sign differs from a's.
- R6: For op code 4 (shift/move), `result` = b. C loads `shift_carry` and V keeps its previous value.
- R7: For op code 5 (logical), and for the unused codes 6 and 7, `result` = a AND b. C and V both keep their previous values.
- R8: `wb_suppress` is high exactly when `op_valid` is high and the op code is 1 or 3. It is low for all other codes.
- R9: Condition codes 0–7 test a single flag: 0 Z=1, 1 Z=0, 2 C=1, 3 C=0, 4 N=1, 5 N=0, 6 V=1, 7 V=0.
- R10: Condition 8 passes when C=1 and Z=0. Condition 9 passes when C=0 or Z=1.
- R11: Condition 10 passes when N=V, and condition 11 when N≠V. Condition 12 passes when Z=0 and N=V, and condition 13 when Z=1 or N≠V.
- R12: Condition 14 always passes and condition 15 never passes.
- R13: `cond_pass` is computed from the registered flags. During the cycle in which a flag-setting operation is presented, it reflects the old flags. In the following cycle it reflects the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (see R4–R7) |
| set_flags | input | 1 | Allow the operation to update the flags |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand (already shifted) |
| shift_carry | input | 1 | Last bit shifted out by the external shifter |
| cond_code | input | 4 | Condition field to evaluate |
| result | output | 32 | Operation result |
| wb_suppress | output | 1 | Result must not be written back |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |
| cond_pass | output | 1 | Condition field passes on current flags |

## Verification
The hardest state to reach is a held overflow or carry that a later operation must not disturb. V can only be set by a signed overflow, and it must then survive shift and logical operations while C changes or stays fixed independently.

The directed sequence forces this state on purpose. A subtract of 1 from the most negative value sets V=1. A shift with a known carry and a logical AND follow, and V is checked after each of them. Every flag combination reached along the way is then swept through all sixteen condition codes.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;

   typedef enum logic [2:0] {
      OP_ADD      = 3'd0,
      OP_ADD_TEST = 3'd1,
      OP_SUB      = 3'd2,
      OP_SUB_TEST = 3'd3,
      OP_SHIFT    = 3'd4,
      OP_LOGIC    = 3'd5,
      OP_SPARE6   = 3'd6,
      OP_SPARE7   = 3'd7
   } op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   localparam int COND_W = 4;

endpackage

// File: rtl/flag_alu.sv
module flag_alu
   import flag_unit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  op_e               op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              shift_c,
   input  nzcv_t             cur,
   output logic [DATA_W-1:0] res,
   output nzcv_t             nxt,
   output logic              test_op
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("flag_alu: DATA_W must be at least 2");
   end

   logic [DATA_W:0] sum_x;
   logic [DATA_W:0] dif_x;
   logic            ovf_add;
   logic            ovf_sub;

   always_comb begin
      sum_x   = {1'b0, a} + {1'b0, b};
      dif_x   = {1'b0, a} - {1'b0, b};
      ovf_add = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
      ovf_sub = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);
   end

   always_comb begin
      res   = a & b;
      nxt.c = cur.c;
      nxt.v = cur.v;
      unique case (op)
         OP_ADD, OP_ADD_TEST: begin
            res   = sum_x[MSB:0];
            nxt.c = sum_x[DATA_W];
            nxt.v = ovf_add;
         end
         OP_SUB, OP_SUB_TEST: begin
            res   = dif_x[MSB:0];
            nxt.c = ~dif_x[DATA_W];
            nxt.v = ovf_sub;
         end
         OP_SHIFT: begin
            res   = b;
            nxt.c = shift_c;
         end
         default: ;
      endcase
      nxt.n = res[MSB];
      nxt.z = (res == '0);
   end

   assign test_op = (op == OP_ADD_TEST) || (op == OP_SUB_TEST);

endmodule

// File: rtl/flag_reg.sv
module flag_reg
   import flag_unit_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  load,
   input  nzcv_t d,
   output nzcv_t q
);

   always_ff @(posedge clk) begin
      if (rst)       q <= '0;
      else if (load) q <= d;
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> (q == '0)); // R1

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q)); // R2

endmodule

// File: rtl/cond_eval.sv
module cond_eval
   import flag_unit_pkg::*;
(
   input  logic [COND_W-1:0] cond,
   input  nzcv_t             f,
   output logic              pass
);
   localparam int N_PAIR = (1 << COND_W) / 2;

   if (COND_W != 4) begin : g_bad_cond
      $error("cond_eval: condition field must be 4 bits");
   end

   // Even codes test base[k]; the odd neighbour is its inverse.
   logic [N_PAIR-1:0]      base;
   logic [2*N_PAIR-1:0]    tbl;

   always_comb begin
      base[0] = f.z;
      base[1] = f.c;
      base[2] = f.n;
      base[3] = f.v;
      base[4] = f.c & ~f.z;
      base[5] = (f.n == f.v);
      base[6] = ~f.z & (f.n == f.v);
      base[7] = 1'b1;
   end

   for (genvar k = 0; k < N_PAIR; k++) begin : g_pair
      assign tbl[2*k]   = base[k];
      assign tbl[2*k+1] = ~base[k];
   end

   assign pass = tbl[cond];

endmodule

// File: rtl/flag_unit.sv
module flag_unit
   import flag_unit_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic              set_flags,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              shift_carry,
   input  logic [3:0]        cond_code,
   output logic [DATA_W-1:0] result,
   output logic              wb_suppress,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              cond_pass
);
   localparam int MSB = DATA_W - 1;

   op_e   op_s;
   nzcv_t cur_f;
   nzcv_t nxt_f;
   logic  test_op;
   logic  load;

   assign op_s = op_e'(op_code);
   assign load = op_valid & set_flags;

   flag_alu #(.DATA_W(DATA_W)) u_alu (
      .op      (op_s),
      .a       (opnd_a),
      .b       (opnd_b),
      .shift_c (shift_carry),
      .cur     (cur_f),
      .res     (result),
      .nxt     (nxt_f),
      .test_op (test_op)
   );

   flag_reg u_flags (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (nxt_f),
      .q    (cur_f)
   );

   cond_eval u_cond (
      .cond (cond_code),
      .f    (cur_f),
      .pass (cond_pass)
   );

   assign wb_suppress = op_valid & test_op;
   assign flag_n      = cur_f.n;
   assign flag_z      = cur_f.z;
   assign flag_c      = cur_f.c;
   assign flag_v      = cur_f.v;

   AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
      load |=> (flag_n == $past(result[MSB]))); // R3

   AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
      load |=> (flag_z == ($past(result) == '0))); // R3

   AST_SHIFT_CARRY: assert property (@(posedge clk) disable iff (rst)
      (load && op_code == 3'd4) |=> (flag_c == $past(shift_carry))); // R6

   AST_SHIFT_KEEP_V: assert property (@(posedge clk) disable iff (rst)
      (load && op_code == 3'd4) |=> $stable(flag_v)); // R6

   AST_LOGIC_KEEP_CV: assert property (@(posedge clk) disable iff (rst)
      (load && op_code == 3'd5) |=> $stable({flag_c, flag_v})); // R7

   AST_SUPPRESS_TEST: assert property (@(posedge clk) disable iff (rst)
      (op_valid && (op_code == 3'd1 || op_code == 3'd3)) |-> wb_suppress); // R8

   AST_NEVER_PASSES: assert property (@(posedge clk) disable iff (rst)
      (cond_code == 4'hF) |-> !cond_pass); // R12

   AST_ALWAYS_PASSES: assert property (@(posedge clk) disable iff (rst)
      (cond_code == 4'hE) |-> cond_pass); // R12

endmodule

// File: tb/flag_unit_tb.sv
`timescale 1ns/100ps
module flag_unit_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic        set_flags = 1'b0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic        shift_carry = 1'b0;
   logic [3:0]  cond_code = '0;
   logic [31:0] result;
   logic        wb_suppress, flag_n, flag_z, flag_c, flag_v, cond_pass;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model of the flags
   logic mn = 0, mz = 0, mc = 0, mv = 0;

   always #5 clk = ~clk;

   flag_unit u_dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
      .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .shift_carry(shift_carry), .cond_code(cond_code), .result(result),
      .wb_suppress(wb_suppress), .flag_n(flag_n), .flag_z(flag_z),
      .flag_c(flag_c), .flag_v(flag_v), .cond_pass(cond_pass)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic cond_model(input logic [3:0] cc, input logic n, z, c, v);
      logic b;
      case (cc[3:1])
         3'd0: b = z;
         3'd1: b = c;
         3'd2: b = n;
         3'd3: b = v;
         3'd4: b = c & ~z;
         3'd5: b = (n == v);
         3'd6: b = ~z & (n == v);
         default: b = 1'b1;
      endcase
      return cc[0] ? ~b : b;
   endfunction

   task automatic chk_flags(input string req);
      chk({req, " flags NZCV"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mn, mz, mc, mv});
   endtask

   task automatic sweep_cond();
      for (int k = 0; k < 16; k++) begin
         string req;
         cond_code = 4'(k);
         #0.2;
         req = (k < 8) ? "R9" : (k < 10) ? "R10" : (k < 14) ? "R11" : "R12";
         chk($sformatf("%s cond=%0d", req, k), {31'd0, cond_pass},
             {31'd0, cond_model(4'(k), mn, mz, mc, mv)});
      end
   endtask

   task automatic run_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sc, input logic vld, input logic sf, input string req);
      logic [32:0] s;
      logic [31:0] r;
      logic c, v;
      case (op)
         3'd0, 3'd1: begin
            s = {1'b0, a} + {1'b0, b}; r = s[31:0]; c = s[32];
            v = (a[31] == b[31]) && (r[31] != a[31]);
         end
         3'd2, 3'd3: begin
            r = a - b; c = (a >= b);
            v = (a[31] != b[31]) && (r[31] != a[31]);
         end
         3'd4: begin r = b; c = sc; v = mv; end
         default: begin r = a & b; c = mc; v = mv; end
      endcase
      @(negedge clk);
      op_valid = vld; op_code = op; opnd_a = a; opnd_b = b;
      shift_carry = sc; set_flags = sf;
      #1;
      chk({req, " result"}, result, r);
      chk("R8 wb_suppress", {31'd0, wb_suppress}, {31'd0, vld && (op == 3'd1 || op == 3'd3)});
      if (vld && sf) begin
         mn = r[31]; mz = (r == 32'd0); mc = c; mv = v;
      end
      @(posedge clk);
      #1;
      op_valid = 1'b0; set_flags = 1'b0;
      chk_flags(vld && sf ? req : "R2");
   endtask

   task automatic t_reset();
      chk_flags("R1");
      sweep_cond();
   endtask

   task automatic t_add();
      run_op(3'd0, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b1, "R4 R3 add carry zero");
      sweep_cond();
      run_op(3'd1, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b1, 1'b1, "R4 add-test overflow");
      sweep_cond();
   endtask

   task automatic t_sub();
      run_op(3'd3, 32'd5, 32'd6, 1'b0, 1'b1, 1'b1, "R5 compare 5 vs 6 borrow");
      chk("R5 C after 5-6", {31'd0, flag_c}, 32'd0);
      sweep_cond();
      run_op(3'd2, 32'd6, 32'd5, 1'b0, 1'b1, 1'b1, "R5 6-5 no borrow");
      sweep_cond();
      run_op(3'd2, 32'h8000_0000, 32'h1, 1'b0, 1'b1, 1'b1, "R5 signed overflow");
      chk("R5 V set", {31'd0, flag_v}, 32'd1);
      sweep_cond();
   endtask

   task automatic t_keep();
      // V=1, C=1 held from previous subtract
      run_op(3'd4, 32'h0, 32'h0000_0000, 1'b0, 1'b1, 1'b1, "R6 shift carry 0");
      chk("R6 V held", {31'd0, flag_v}, 32'd1);
      sweep_cond();
      run_op(3'd4, 32'h0, 32'h8000_0001, 1'b1, 1'b1, 1'b1, "R6 shift carry 1");
      run_op(3'd5, 32'hF0F0_0000, 32'h0F0F_0000, 1'b0, 1'b1, 1'b1, "R7 logic keeps C V");
      chk("R7 C,V held", {30'd0, flag_c, flag_v}, 32'd3);
      sweep_cond();
      run_op(3'd7, 32'hFFFF_0000, 32'hF000_F000, 1'b0, 1'b1, 1'b1, "R7 spare code as logic");
   endtask

   task automatic t_no_update();
      run_op(3'd2, 32'd1, 32'd1, 1'b0, 1'b1, 1'b0, "R2 set_flags low");
      run_op(3'd2, 32'd0, 32'd1, 1'b1, 1'b0, 1'b1, "R2 valid low");
   endtask

   task automatic t_follow();
      // flags now: from last loaded op; set a known state first
      run_op(3'd2, 32'd9, 32'd9, 1'b0, 1'b1, 1'b1, "R5 equal compare");
      // present 5-6 compare; during its cycle condition 0 (Z set) still passes
      @(negedge clk);
      op_valid = 1'b1; op_code = 3'd3; opnd_a = 32'd5; opnd_b = 32'd6; set_flags = 1'b1;
      cond_code = 4'd0;
      #1;
      chk("R13 old flags during op", {31'd0, cond_pass}, 32'd1);
      @(posedge clk);
      #1;
      op_valid = 1'b0; set_flags = 1'b0;
      mn = 1'b1; mz = 1'b0; mc = 1'b0; mv = 1'b0;
      cond_code = 4'd9;
      #0.2;
      chk("R13 lower-or-same next cycle", {31'd0, cond_pass}, 32'd1);
      cond_code = 4'd0;
      #0.2;
      chk("R13 equal no longer passes", {31'd0, cond_pass}, 32'd0);
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #1;
      rst = 1'b0;
      mn = 0; mz = 0; mc = 0; mv = 0;
      chk_flags("R1 mid-run reset");
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #1;
      rst = 1'b0;
      t_reset();
      t_add();
      t_sub();
      t_keep();
      t_no_update();
      t_follow();
      t_reset_mid();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule